// File: doc/BRIEF.md
# Video Sync Source with Automatic Free-Run Fallback

This block gives an on-screen display the line and field timing it needs. While a sync source is connected, it follows the incoming horizontal and vertical pulses. It clears its pixel counter on every accepted horizontal leading edge. It clears its line counter on every vertical leading edge, and it marks the field as odd or even from where that vertical edge falls within the line.

When no acceptable horizontal pulse has arrived for several line periods, the block concludes that sync is missing and switches to free-running timing. It then drives its own horizontal and vertical pulses out on the same bidirectional pins toward the deflection stage. It drives a pin only while its own pulse is active and releases it between pulses, so a returning source can still be seen on the pin.

All time constants are given in microseconds and scaled by a clocks-per-microsecond parameter. Either direction of mode change takes effect only at a line start, so no shortened pulse reaches the pins.

Top module: `vss_sync_source`

## Requirements
- R1: While reset is held, the block is in free-run mode: ext_locked=0, pix_count=0, line_count=0 and field_odd=0.
- R2: In free-run mode a line lasts 64 µs, and hsync_oe/hsync_out are high for the first 11 µs of each line.
- R3: In free-run mode, even fields (field_odd=0) last 262 lines and odd fields (field_odd=1) last 263 lines, alternately. The even-field vertical pulse starts with a line (pix_count=0) and the odd-field pulse starts half a line in (pix_count=32 µs), so vertical leading edges are exactly 262.5 lines apart.
- R4: A pin's output enable is high only while the block's own generated pulse is active: it is low between free-run pulses and never high in external mode.
- R5: An incoming horizontal pulse counts as valid only if its width lies between 5.5 µs and 12.5 µs, rounded inward to whole clocks. Pulses outside that range never lead to external lock.
- R6: From free-run mode, the block returns to external mode after 8 consecutive valid horizontal pulses. Seven pulses are not enough.
- R7: In external mode, the block declares sync lost once no valid horizontal pulse has arrived for 4 line periods. It then enters free-run mode.
- R8: Mode changes occur only at a line start, and the first generated horizontal pulse after a change to free-run mode is a full 11 µs.
- R9: In external mode an accepted horizontal leading edge clears pix_count and advances line_count by one. With the two-stage input synchronizer, pix_count reads k-3 at k clocks after the pin rises.
- R10: In external mode an incoming vertical leading edge clears line_count. It sets field_odd=0 if it falls within 12 µs of a line start (either side), sets field_odd=1 if it falls 20 µs to 44 µs after the line start, and leaves field_odd unchanged otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| hsync_in | input | 1 | Horizontal sync pin, read side |
| vsync_in | input | 1 | Vertical sync pin, read side |
| hsync_out | output | 1 | Generated horizontal pulse level |
| hsync_oe | output | 1 | Output enable for the horizontal pin |
| vsync_out | output | 1 | Generated vertical pulse level |
| vsync_oe | output | 1 | Output enable for the vertical pin |
| pix_count | output | PW (10) | Clock position within the current line |
| line_count | output | LW (9) | Line index within the current field |
| field_odd | output | 1 | 1 during an odd field |
| line_start | output | 1 | One-clock strobe at each line boundary |
| ext_locked | output | 1 | 1 while timing follows the external pins |

## Verification
The bench builds the block with CLK_PER_US=1, so a line is 64 clocks, the loss window is 256 clocks and the valid pulse widths are exactly 6 to 12 clocks. With these values, both interlaced free-run fields (16800 clocks between vertical edges) fit in one run. So do the width limits on either side, the seventh-versus-eighth-pulse lock point and the full loss-and-fallback sequence. Parity is probed at vertical offsets that land on even, odd, unclassified and late-even phases.

// File: rtl/vss_pkg.sv
package vss_pkg;

  typedef enum logic [1:0] {PH_EVEN, PH_ODD, PH_NONE} phase_e;

  // tenths of a microsecond to clocks, rounded up
  function automatic int cyc_ceil(int tenths, int cpu);
    return (tenths * cpu + 9) / 10;
  endfunction

  // tenths of a microsecond to clocks, rounded down
  function automatic int cyc_floor(int tenths, int cpu);
    return (tenths * cpu) / 10;
  endfunction

  // classify a vertical leading edge by its position inside the line
  function automatic phase_e classify(int pix, int line_cyc, int cpu);
    int near_lim;
    int odd_lo;
    int odd_hi;
    near_lim = cyc_floor(120, cpu);
    odd_lo   = cyc_ceil(200, cpu);
    odd_hi   = cyc_floor(440, cpu);
    if (pix <= near_lim || pix >= line_cyc - near_lim) return PH_EVEN;
    if (pix >= odd_lo && pix <= odd_hi) return PH_ODD;
    return PH_NONE;
  endfunction

endpackage

// File: rtl/vss_sync.sv
module vss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], din};
  end

  assign level = sh[STAGES-1];
endmodule

// File: rtl/vss_lockmon.sv
module vss_lockmon import vss_pkg::*; #(
  parameter int CLK_PER_US    = 12,
  parameter int LINE_CYC      = 768,
  parameter int LOSS_LINES    = 4,
  parameter int RESTORE_LINES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_level,
  input  logic hs_rise,
  input  logic hs_fall,
  input  logic drive_mask,
  output logic lost
);
  localparam int HMIN = cyc_ceil(55, CLK_PER_US);
  localparam int HMAX = cyc_floor(125, CLK_PER_US);
  localparam int LOSS = LOSS_LINES * LINE_CYC;
  localparam int WW   = $clog2(HMAX + 2);
  localparam int GW   = $clog2(LOSS + 1);
  localparam int CW   = $clog2(RESTORE_LINES + 1);

  logic [WW-1:0] wid;
  logic          tainted;
  logic [GW-1:0] gap;
  logic [CW-1:0] good;
  logic          valid_pulse;
  logic          timeout;

  // width of the pulse now ending, and whether own drive overlapped it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wid     <= '0;
      tainted <= 1'b0;
    end else if (hs_rise) begin
      wid     <= WW'(1);
      tainted <= drive_mask;
    end else if (hs_level) begin
      if (int'(wid) <= HMAX) wid <= wid + 1'b1;
      tainted <= tainted | drive_mask;
    end
  end

  assign valid_pulse = hs_fall && !tainted && int'(wid) >= HMIN && int'(wid) <= HMAX;
  assign timeout     = int'(gap) == LOSS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap  <= '0;
      good <= '0;
      lost <= 1'b1;
    end else begin
      if (valid_pulse)   gap <= '0;
      else if (!timeout) gap <= gap + 1'b1;

      if (valid_pulse) begin
        if (lost) begin
          if (int'(good) == RESTORE_LINES - 1) begin
            lost <= 1'b0;
            good <= '0;
          end else begin
            good <= good + 1'b1;
          end
        end
      end else if (timeout) begin
        lost <= 1'b1;
        good <= '0;
      end
    end
  end

  // R7: loss is only ever declared after the full silent window
  a_r7_loss_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost) |-> $past(timeout))
    else $error("loss declared before window expired");

  // R6: recovery only on the qualifying valid pulse
  a_r6_restore_on_count: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lost) |-> ($past(valid_pulse) && $past(good) == CW'(RESTORE_LINES - 1)))
    else $error("recovery without enough valid pulses");
endmodule

// File: rtl/vss_timebase.sv
module vss_timebase import vss_pkg::*; #(
  parameter int CLK_PER_US  = 12,
  parameter int VS_LINES    = 3,
  parameter int LINES_SHORT = 262,
  localparam int LINE_CYC   = 64 * CLK_PER_US,
  localparam int PW         = $clog2(LINE_CYC),
  localparam int LW         = $clog2(LINES_SHORT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lost,
  input  logic          hs_rise,
  input  logic          vs_rise,
  output logic          int_mode,
  output logic [PW-1:0] pix,
  output logic [LW-1:0] line,
  output logic          field_odd,
  output logic          line_start,
  output logic          hs_drv,
  output logic          vs_drv
);
  localparam int HS_CYC = 11 * CLK_PER_US;
  localparam int HALF   = LINE_CYC / 2;

  logic   ext_vs;
  logic   hs_gen;
  logic   vs_gen;
  int     last_line;
  phase_e ph;

  assign line_start = (int'(pix) == LINE_CYC - 1) || (!int_mode && hs_rise);
  assign ext_vs     = !int_mode && vs_rise;
  assign ph         = classify(int'(pix), LINE_CYC, CLK_PER_US);
  assign last_line  = field_odd ? LINES_SHORT : LINES_SHORT - 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix       <= '0;
      line      <= '0;
      field_odd <= 1'b0;
      int_mode  <= 1'b1;
    end else begin
      pix <= line_start ? '0 : pix + 1'b1;
      if (line_start) int_mode <= lost;
      if (ext_vs) begin
        line <= '0;
        if (ph == PH_EVEN)     field_odd <= 1'b0;
        else if (ph == PH_ODD) field_odd <= 1'b1;
      end else if (line_start) begin
        if (int'(line) == last_line) begin
          line      <= '0;
          field_odd <= ~field_odd;
        end else begin
          line <= line + 1'b1;
        end
      end
    end
  end

  assign hs_gen = int'(pix) < HS_CYC;
  always_comb begin
    if (!field_odd) vs_gen = int'(line) < VS_LINES;
    else vs_gen = (int'(line) == 0 && int'(pix) >= HALF) ||
                  (int'(line) > 0 && int'(line) < VS_LINES) ||
                  (int'(line) == VS_LINES && int'(pix) < HALF);
  end
  assign hs_drv = int_mode & hs_gen;
  assign vs_drv = int_mode & vs_gen;

  // R8: source selection changes only on a line boundary
  a_r8_switch_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mode != $past(int_mode)) |-> $past(line_start))
    else $error("mode changed mid-line");

  // R2: pixel position stays inside one line
  a_r2_pix_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pix) < LINE_CYC)
    else $error("pixel counter overran line");

  // R3: line index never exceeds the longer field
  a_r3_line_in_field: assert property (@(posedge clk) disable iff (!rst_n)
    int'(line) <= LINES_SHORT)
    else $error("line counter overran field");
endmodule

// File: rtl/vss_sync_source.sv
module vss_sync_source import vss_pkg::*; #(
  parameter int CLK_PER_US    = 12,
  parameter int SYNC_STAGES   = 2,
  parameter int LOSS_LINES    = 4,
  parameter int RESTORE_LINES = 8,
  parameter int VS_LINES      = 3,
  parameter int LINES_SHORT   = 262,
  localparam int LINE_CYC     = 64 * CLK_PER_US,
  localparam int PW           = $clog2(LINE_CYC),
  localparam int LW           = $clog2(LINES_SHORT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync_in,
  input  logic          vsync_in,
  output logic          hsync_out,
  output logic          hsync_oe,
  output logic          vsync_out,
  output logic          vsync_oe,
  output logic [PW-1:0] pix_count,
  output logic [LW-1:0] line_count,
  output logic          field_odd,
  output logic          line_start,
  output logic          ext_locked
);
  localparam int HS_CYC = 11 * CLK_PER_US;
  localparam int RW     = $clog2(LINE_CYC + 1);

  logic [1:0] pin_raw, pin_lvl, pin_prev;
  logic       hs_rise, hs_fall, vs_rise;
  logic       lost, int_mode, hs_drv, vs_drv;
  logic [RW-1:0] run;

  assign pin_raw = {vsync_in, hsync_in};

  for (genvar g = 0; g < 2; g++) begin : g_pin
    vss_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pin_raw[g]),
      .level (pin_lvl[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pin_prev <= '0;
    else        pin_prev <= pin_lvl;
  end

  assign hs_rise = pin_lvl[0] & ~pin_prev[0];
  assign hs_fall = ~pin_lvl[0] & pin_prev[0];
  assign vs_rise = pin_lvl[1] & ~pin_prev[1];

  vss_lockmon #(
    .CLK_PER_US    (CLK_PER_US),
    .LINE_CYC      (LINE_CYC),
    .LOSS_LINES    (LOSS_LINES),
    .RESTORE_LINES (RESTORE_LINES)
  ) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .hs_level   (pin_lvl[0]),
    .hs_rise    (hs_rise),
    .hs_fall    (hs_fall),
    .drive_mask (hs_drv),
    .lost       (lost)
  );

  vss_timebase #(
    .CLK_PER_US  (CLK_PER_US),
    .VS_LINES    (VS_LINES),
    .LINES_SHORT (LINES_SHORT)
  ) u_tb (
    .clk        (clk),
    .rst_n      (rst_n),
    .lost       (lost),
    .hs_rise    (hs_rise),
    .vs_rise    (vs_rise),
    .int_mode   (int_mode),
    .pix        (pix_count),
    .line       (line_count),
    .field_odd  (field_odd),
    .line_start (line_start),
    .hs_drv     (hs_drv),
    .vs_drv     (vs_drv)
  );

  assign hsync_out  = hs_drv;
  assign hsync_oe   = hs_drv;
  assign vsync_out  = vs_drv;
  assign vsync_oe   = vs_drv;
  assign ext_locked = !int_mode;

  // length of the current driven horizontal pulse
  always_ff @(posedge clk) begin
    if (!rst_n || !hsync_oe) run <= '0;
    else                     run <= run + 1'b1;
  end

  // R8: every driven horizontal pulse is full width, none cut short
  a_r8_full_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync_oe) |-> int'(run) == HS_CYC)
    else $error("runt horizontal pulse driven");

  // R4: the pin is driven only outside external mode
  a_r4_drive_free_run_only: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync_oe || vsync_oe) |-> !ext_locked)
    else $error("pin driven while locked to external sync");
endmodule

// File: tb/vss_sync_source_test.sv
module vss_sync_source_test;
  localparam int CPU  = 1;
  localparam int LINE = 64;
  localparam int PW   = $clog2(64 * CPU);
  localparam int LW   = $clog2(263);

  // each row: horizontal pulse width in clocks, expected lock after 10 lines
  localparam int NV = 6;
  localparam int VEC [NV][2] = '{'{5, 0}, '{6, 1}, '{11, 1}, '{12, 1}, '{13, 0}, '{3, 0}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_hs = 1'b0;
  logic ext_vs = 1'b0;
  logic hs_pin, vs_pin;
  logic hsync_out, hsync_oe, vsync_out, vsync_oe;
  logic [PW-1:0] pix_count;
  logic [LW-1:0] line_count;
  logic field_odd, line_start, ext_locked;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  int probe_pix, probe_line, oe_hits, n;

  always #4 clk = ~clk;

  assign hs_pin = hsync_oe ? hsync_out : ext_hs;
  assign vs_pin = vsync_oe ? vsync_out : ext_vs;

  vss_sync_source #(.CLK_PER_US(CPU)) uut (
    .clk(clk), .rst_n(rst_n), .hsync_in(hs_pin), .vsync_in(vs_pin),
    .hsync_out(hsync_out), .hsync_oe(hsync_oe),
    .vsync_out(vsync_out), .vsync_oe(vsync_oe),
    .pix_count(pix_count), .line_count(line_count), .field_odd(field_odd),
    .line_start(line_start), .ext_locked(ext_locked)
  );

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  // one 64-clock line of external stimulus; probes outputs at clock 20
  task automatic send_line(input int w, input int vs_off, input bit vs_val);
    oe_hits = 0;
    for (int c = 0; c < LINE; c++) begin
      @(negedge clk);
      if (c == 20) begin
        probe_pix  = int'(pix_count);
        probe_line = int'(line_count);
      end
      if (hsync_oe) oe_hits++;
      ext_hs = (c < w);
      if (c == vs_off) ext_vs = vs_val;
    end
  endtask

  task automatic reset_align();
    @(negedge clk);
    rst_n = 1'b0; ext_hs = 1'b0; ext_vs = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    while (hsync_oe) @(negedge clk);
    while (!hsync_oe) @(negedge clk);
    repeat (30) @(negedge clk);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung run, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check("R1 ext_locked", int'(ext_locked), 0);
    check("R1 pix_count", int'(pix_count), 0);
    check("R1 line_count", int'(line_count), 0);
    check("R1 field_odd", int'(field_odd), 0);
    rst_n = 1'b1;

    // R2: free-run line period and pulse width
    while (hsync_oe) @(negedge clk);
    while (!hsync_oe) @(negedge clk);
    n = 0;
    while (hsync_oe) begin @(negedge clk); n++; end
    check("R2 hsync width", n, 11);
    while (!hsync_oe) begin @(negedge clk); n++; end
    check("R2 line period", n, 64);
    repeat (30) @(negedge clk);
    check("R4 released between pulses", int'(hsync_oe), 0);

    // R3: interlaced fields
    while (vsync_oe) @(negedge clk);
    while (!vsync_oe) @(negedge clk);
    check("R3 odd field flag", int'(field_odd), 1);
    check("R3 odd vsync offset", int'(pix_count), 32);
    n = 0;
    while (vsync_oe) begin @(negedge clk); n++; end
    while (!vsync_oe) begin @(negedge clk); n++; end
    check("R3 odd-to-even spacing", n, 16800);
    check("R3 even field flag", int'(field_odd), 0);
    check("R3 even vsync offset", int'(pix_count), 0);
    n = 0;
    while (vsync_oe) begin @(negedge clk); n++; end
    while (!vsync_oe) begin @(negedge clk); n++; end
    check("R3 even-to-odd spacing", n, 16800);
    check("R3 odd again", int'(field_odd), 1);

    // R5: pulse width qualification, table driven
    for (int i = 0; i < NV; i++) begin
      reset_align();
      for (int k = 0; k < 10; k++) send_line(VEC[i][0], -1, 1'b0);
      check($sformatf("R5 width %0d lock", VEC[i][0]), int'(ext_locked), VEC[i][1]);
    end

    // R6: seven valid pulses do not lock, the eighth does
    reset_align();
    for (int k = 0; k < 7; k++) send_line(11, -1, 1'b0);
    check("R6 seven pulses", int'(ext_locked), 0);
    send_line(11, -1, 1'b0);
    check("R6 eighth pulse", int'(ext_locked), 1);

    // R4 and R9: no drive in external mode, counters follow the pin
    send_line(11, -1, 1'b0);
    check("R4 no drive when locked", oe_hits, 0);
    check("R9 pix after edge", probe_pix, 17);
    n = probe_line;
    send_line(11, -1, 1'b0);
    check("R9 pix next line", probe_pix, 17);
    check("R9 line advance", probe_line, (n + 1) % 262);

    // R10: field parity from vertical edge position
    send_line(11, 2, 1'b1);
    send_line(11, 0, 1'b0);
    check("R10 near edge even", int'(field_odd), 0);
    check("R10 line cleared", probe_line, 1);
    send_line(11, 32, 1'b1);
    send_line(11, 0, 1'b0);
    check("R10 mid offset odd", int'(field_odd), 1);
    check("R10 line cleared odd", probe_line, 1);
    send_line(11, 16, 1'b1);
    send_line(11, 0, 1'b0);
    check("R10 gap offset unchanged", int'(field_odd), 1);
    check("R10 line cleared gap", probe_line, 1);
    send_line(11, 60, 1'b1);
    send_line(11, 0, 1'b0);
    check("R10 late edge even", int'(field_odd), 0);

    // R7: loss after four silent lines, not before
    send_line(11, -1, 1'b0);
    for (int k = 0; k < 3; k++) send_line(0, -1, 1'b0);
    check("R7 still locked at 3 lines", int'(ext_locked), 1);
    for (int k = 0; k < 2; k++) send_line(0, -1, 1'b0);
    check("R7 free-run after loss", int'(ext_locked), 0);

    // R8: first generated pulse after fallback is full width
    while (hsync_oe) @(negedge clk);
    while (!hsync_oe) @(negedge clk);
    n = 0;
    while (hsync_oe) begin @(negedge clk); n++; end
    check("R8 full pulse after switch", n, 11);

    summary();
  end
endmodule